// File: doc/BRIEF.md
# Configurable Logic Tile (LUT, Carry and Flip-Flop Column)

The block is one programmable logic tile holding a column of eight identical cells. Every cell evaluates a 4-input lookup table, can produce a carry bit for a ripple chain, and can either drive its output straight from the table or through a flip-flop. The tile has one shared clock, one shared clock enable and one shared set/reset line. It has a carry input and a carry output so that several tiles can be stacked into a longer arithmetic chain.

Behaviour is loaded through a write-only configuration port. A write carries a cell index, a field selector and a 16-bit data word. Each cell has three kinds of setting: its 16 truth-table bits; a 4-bit mode word that controls the carry, the register, the set/reset value and the reset style; and two tile-wide flags for clock polarity and carry-in cascade. The port has a valid strobe and no ready line. A write is accepted on every rising clock edge where the strobe is high, so the port never applies back-pressure. A configuration change is only guaranteed to be clean while the shared clock enable is low.

Top module: `logic_tile`

## Requirements
- R1: With mode bit 1 clear, a cell output is combinational and equals truth bit number {in0,in1,in2,in3}: in0 is the most significant index bit, in3 the least significant.
- R2: On a rising clock edge with `cfg_valid` high, a write updates the addressed setting. The field codes are: 0 loads all 16 truth bits from `cfg_data`; 1 loads the cell's mode from `cfg_data[3:0]`; 2 loads the tile flags, with `cfg_data[0]` as falling-edge clocking and `cfg_data[1]` as cascade enable (the cell index is ignored); 3 changes nothing.
- R3: With mode bit 0 set, a cell's carry output is (in1 AND in2) OR ((in1 OR in2) AND cin). With mode bit 0 clear, the carry output is 0.
- R4: For cells 1 to 7, cin is the carry output of the cell below. Cell 0 takes `carry_in` when the cascade flag is set, and 0 otherwise. `carry_out` is the carry output of cell 7.
- R5: With mode bit 1 set, the output comes from a flip-flop. The flip-flop captures the table value on the active clock edge when `ce` is high and holds its value when `ce` is low.
- R6: With mode bit 3 clear, set/reset is synchronous. On an active edge with `ce` and `sr` both high, the flip-flop loads mode bit 2. While `ce` is low, `sr` has no effect.
- R7: With mode bit 3 set, a high `sr` forces the flip-flop to mode bit 2 at once, without a clock edge and regardless of `ce`.
- R8: When the falling-edge flag is set, every flip-flop in the tile captures on the falling edge of `clk` instead of the rising edge.
- R9: While `rst_n` is low, all settings and flip-flops are cleared, so every cell output and `carry_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; configuration is always written on its rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of settings and flip-flops |
| cfg_valid | input | 1 | Write strobe; accepted on every rising edge, no back-pressure |
| cfg_cell | input | 3 | Cell index addressed by the write |
| cfg_field | input | 2 | Field selector (0 truth, 1 mode, 2 tile flags, 3 none) |
| cfg_data | input | 16 | Write data |
| ce | input | 1 | Shared clock enable |
| sr | input | 1 | Shared set/reset |
| carry_in | input | 1 | Carry from the tile below |
| cell_in | input | 32 | Cell c input k at bit 4*c+k |
| cell_out | output | 8 | One output per cell |
| carry_out | output | 1 | Carry to the tile above |

## Verification
The hardest case to reach from the ports is the race between the flip-flop's two set/reset styles, the clock enable and the chosen clock edge. An asynchronous force has to show up between edges. A synchronous request with the enable low must leave the register unchanged, and falling-edge capture must be told apart from rising-edge capture. The stimulus therefore drives inputs 1 ns after a rising edge and samples at fixed offsets around both edges. Even and odd cells get opposite set/reset values and opposite table contents, so a single step shows both a load and a hold, and shows the set and the reset polarity side by side.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int LUT_K  = 4;
  localparam int MODE_W = 4;
  // mode word bit positions
  localparam int M_CARRY = 0;
  localparam int M_REG   = 1;
  localparam int M_VAL   = 2;
  localparam int M_ASYNC = 3;
  // tile flag bit positions
  localparam int F_NEG  = 0;
  localparam int F_CASC = 1;

  typedef enum logic [1:0] {
    FLD_TRUTH = 2'd0,
    FLD_MODE  = 2'd1,
    FLD_TILE  = 2'd2,
    FLD_SPARE = 2'd3
  } fld_e;
endpackage

// File: rtl/tile_lut.sv
module tile_lut
  import tile_pkg::*;
#(
  parameter int K = LUT_K
) (
  input  logic [(1<<K)-1:0] truth,
  input  logic [K-1:0]      sel,
  output logic              y
);
  localparam int N = 1 << K;

  logic [N-1:0] lv [K+1];

  // Binary mux tree: the last input picks between neighbours, the
  // first input makes the final choice between the two halves.
  always_comb begin
    lv[0] = truth;
    for (int l = 0; l < K; l++) begin
      lv[l+1] = '0;
      for (int j = 0; j < (N >> (l+1)); j++)
        lv[l+1][j] = sel[K-1-l] ? lv[l][2*j+1] : lv[l][2*j];
    end
  end

  assign y = lv[K][0];
endmodule

// File: rtl/tile_cfg.sv
module tile_cfg
  import tile_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int TBITS = 1 << LUT_K,
  localparam int CW   = $clog2(NCELL)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_valid,
  input  logic [CW-1:0]                  cfg_cell,
  input  logic [1:0]                     cfg_field,
  input  logic [TBITS-1:0]               cfg_data,
  output logic [NCELL-1:0][TBITS-1:0]    truth_q,
  output logic [NCELL-1:0][MODE_W-1:0]   mode_q,
  output logic                           neg_q,
  output logic                           casc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      truth_q <= '0;
      mode_q  <= '0;
      neg_q   <= 1'b0;
      casc_q  <= 1'b0;
    end else if (cfg_valid) begin
      case (fld_e'(cfg_field))
        FLD_TRUTH: if (int'(cfg_cell) < NCELL) truth_q[cfg_cell] <= cfg_data;
        FLD_MODE:  if (int'(cfg_cell) < NCELL) mode_q[cfg_cell] <= cfg_data[MODE_W-1:0];
        FLD_TILE: begin
          neg_q  <= cfg_data[F_NEG];
          casc_q <= cfg_data[F_CASC];
        end
        default: ;
      endcase
    end
  end

  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_field == FLD_MODE)
      |=> mode_q[$past(cfg_cell)] == $past(cfg_data[MODE_W-1:0]));

  // R2
  truth_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_field == FLD_TRUTH)
      |=> truth_q[$past(cfg_cell)] == $past(cfg_data));
endmodule

// File: rtl/tile_cell.sv
module tile_cell
  import tile_pkg::*;
#(
  parameter int K = LUT_K
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              neg_clk,
  input  logic              ce,
  input  logic              sr,
  input  logic [(1<<K)-1:0] truth,
  input  logic [MODE_W-1:0] mode,
  input  logic [K-1:0]      din,
  input  logic              cin,
  output logic              q_out,
  output logic              cout
);
  logic lut_val;
  logic ff;
  logic clk_eff;
  logic arst;

  tile_lut #(.K(K)) u_lut (
    .truth (truth),
    .sel   (din),
    .y     (lut_val)
  );

  // ripple carry: majority of in1, in2 and cin
  assign cout = mode[M_CARRY] &
                ((din[1] & din[2]) | ((din[1] | din[2]) & cin));

  assign clk_eff = clk ^ neg_clk;
  assign arst    = !rst_n || (sr && mode[M_ASYNC]);

  always_ff @(posedge clk_eff or posedge arst) begin
    if (arst)
      ff <= rst_n ? mode[M_VAL] : 1'b0;
    else if (ce)
      ff <= sr ? mode[M_VAL] : lut_val;
  end

  assign q_out = mode[M_REG] ? ff : lut_val;

  // R1
  comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[M_REG] |-> q_out == lut_val);

  // R7
  async_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[M_REG] && mode[M_ASYNC] && sr) |-> q_out == mode[M_VAL]);

  // R6
  sync_load_chk: assert property (@(posedge clk_eff) disable iff (!rst_n)
    (mode[M_REG] && !mode[M_ASYNC] && ce && sr) |=> ff == $past(mode[M_VAL]));
endmodule

// File: rtl/logic_tile.sv
module logic_tile
  import tile_pkg::*;
#(
  parameter int NCELL = 8,
  localparam int NIN   = LUT_K,
  localparam int TBITS = 1 << LUT_K,
  localparam int CW    = $clog2(NCELL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  input  logic [CW-1:0]         cfg_cell,
  input  logic [1:0]            cfg_field,
  input  logic [TBITS-1:0]      cfg_data,
  input  logic                  ce,
  input  logic                  sr,
  input  logic                  carry_in,
  input  logic [NCELL*NIN-1:0]  cell_in,
  output logic [NCELL-1:0]      cell_out,
  output logic                  carry_out
);
  logic [NCELL-1:0][TBITS-1:0]  truth_q;
  logic [NCELL-1:0][MODE_W-1:0] mode_q;
  logic                         neg_q;
  logic                         casc_q;
  logic [NCELL:0]               cy;

  tile_cfg #(.NCELL(NCELL), .TBITS(TBITS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_cell  (cfg_cell),
    .cfg_field (cfg_field),
    .cfg_data  (cfg_data),
    .truth_q   (truth_q),
    .mode_q    (mode_q),
    .neg_q     (neg_q),
    .casc_q    (casc_q)
  );

  assign cy[0] = casc_q & carry_in;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    tile_cell #(.K(NIN)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .neg_clk (neg_q),
      .ce      (ce),
      .sr      (sr),
      .truth   (truth_q[c]),
      .mode    (mode_q[c]),
      .din     (cell_in[c*NIN +: NIN]),
      .cin     (cy[c]),
      .q_out   (cell_out[c]),
      .cout    (cy[c+1])
    );
  end

  assign carry_out = cy[NCELL];

  // R4
  top_carry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[NCELL-1][M_CARRY] |-> carry_out == 1'b0);

  // R4
  first_cin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_q |-> cy[0] == 1'b0);
endmodule

// File: tb/sim_logic_tile.sv
module sim_logic_tile;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_cell = '0;
  logic [1:0]  cfg_field = '0;
  logic [15:0] cfg_data = '0;
  logic        ce = 1'b0;
  logic        sr = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] cell_in = '0;
  logic [7:0]  cell_out;
  logic        carry_out;

  int total = 0;
  int bad = 0;
  logic [15:0] tt [NC];

  always #4 clk = ~clk;

  logic_tile u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cell(cfg_cell),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .ce(ce), .sr(sr),
    .carry_in(carry_in), .cell_in(cell_in), .cell_out(cell_out),
    .carry_out(carry_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int c, input logic [1:0] f, input logic [15:0] d);
    cfg_valid = 1'b1; cfg_cell = 3'(c); cfg_field = f; cfg_data = d;
    step();
    cfg_valid = 1'b0;
  endtask

  // put index value v on every cell as {in0,in1,in2,in3}
  function automatic logic [3:0] pack_idx(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic set_all(input logic [3:0] v);
    for (int c = 0; c < NC; c++) cell_in[c*4 +: 4] = pack_idx(v);
  endtask

  function automatic logic [7:0] expect_lut(input logic [3:0] v);
    logic [7:0] e;
    for (int c = 0; c < NC; c++) e[c] = tt[c][v];
    return e;
  endfunction

  task automatic t_reset();
    chk("R9 outputs in reset", {23'd0, carry_out, cell_out}, 32'd0);
    rst_n = 1'b1;
    step();
    cell_in = '1; carry_in = 1'b1;
    #1;
    chk("R9 cleared settings after reset", {23'd0, carry_out, cell_out}, 32'd0);
    cell_in = '0; carry_in = 1'b0;
  endtask

  task automatic t_lut();
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < NC; c++) begin
        tt[c] = 16'($urandom);
        wr(c, 2'd0, tt[c]);
        wr(c, 2'd1, 16'h0000);
      end
      for (int v = 0; v < 16; v++) begin
        set_all(4'(v));
        #1;
        chk($sformatf("R1 lut index %0d", v), {24'd0, cell_out}, {24'd0, expect_lut(4'(v))});
      end
    end
    // field 3 must leave everything unchanged
    wr(0, 2'd3, 16'hFFFF);
    set_all(4'd5);
    #1;
    chk("R2 spare field ignored", {24'd0, cell_out}, {24'd0, expect_lut(4'd5)});
  endtask

  task automatic t_carry();
    logic cy;
    wr(0, 2'd2, 16'h0002);
    for (int c = 0; c < NC; c++) wr(c, 2'd1, 16'h0001);
    for (int r = 0; r < 20; r++) begin
      cell_in = $urandom;
      carry_in = 1'($urandom);
      cy = carry_in;
      for (int c = 0; c < NC; c++) begin
        logic a, b;
        a = cell_in[c*4+1]; b = cell_in[c*4+2];
        cy = (a & b) | ((a | b) & cy);
      end
      #1;
      chk("R3 R4 carry chain", {31'd0, carry_out}, {31'd0, cy});
    end
    // propagate everywhere: in1=1 in2=0
    for (int c = 0; c < NC; c++) cell_in[c*4 +: 4] = 4'b0010;
    carry_in = 1'b1;
    #1;
    chk("R4 cascade on passes carry_in", {31'd0, carry_out}, 32'd1);
    wr(0, 2'd2, 16'h0000);
    #1;
    chk("R4 cascade off gives cin 0", {31'd0, carry_out}, 32'd0);
    wr(0, 2'd2, 16'h0002);
    wr(7, 2'd1, 16'h0000);
    #1;
    chk("R3 carry disabled on top cell", {31'd0, carry_out}, 32'd0);
    carry_in = 1'b0;
  endtask

  task automatic t_reg();
    for (int c = 0; c < NC; c++) begin
      tt[c] = 16'($urandom);
      wr(c, 2'd0, tt[c]);
      wr(c, 2'd1, 16'h0002);
    end
    ce = 1'b1;
    for (int v = 0; v < 16; v += 3) begin
      set_all(4'(v));
      step();
      chk("R5 registered capture", {24'd0, cell_out}, {24'd0, expect_lut(4'(v))});
    end
    ce = 1'b0;
    set_all(4'd1);
    step();
    chk("R5 hold with ce low", {24'd0, cell_out}, {24'd0, expect_lut(4'd15)});
  endtask

  task automatic t_sync();
    for (int c = 0; c < NC; c++) begin
      wr(c, 2'd0, 16'hFFFF);
      wr(c, 2'd1, (c % 2 == 0) ? 16'h0006 : 16'h0002);
    end
    ce = 1'b1; sr = 1'b0;
    step();
    chk("R6 preload ones", {24'd0, cell_out}, 32'hFF);
    ce = 1'b0; sr = 1'b1;
    step();
    chk("R6 sr ignored with ce low", {24'd0, cell_out}, 32'hFF);
    ce = 1'b1;
    step();
    chk("R6 sync set and reset", {24'd0, cell_out}, 32'h55);
    ce = 1'b0; sr = 1'b0;
  endtask

  task automatic t_async();
    for (int c = 0; c < NC; c++) begin
      wr(c, 2'd0, (c % 2 == 0) ? 16'h0000 : 16'hFFFF);
      wr(c, 2'd1, (c % 2 == 0) ? 16'h000E : 16'h000A);
    end
    ce = 1'b1;
    step();
    chk("R7 preload", {24'd0, cell_out}, 32'hAA);
    ce = 1'b0;
    sr = 1'b1;
    #1;
    chk("R7 immediate async force", {24'd0, cell_out}, 32'h55);
    step();
    sr = 1'b0;
    step();
    chk("R7 forced value held", {24'd0, cell_out}, 32'h55);
  endtask

  task automatic t_neg();
    for (int c = 0; c < NC; c++) begin
      tt[c] = 16'($urandom);
      tt[c][3] = 1'b0;
      tt[c][12] = 1'b1;
      wr(c, 2'd0, tt[c]);
      wr(c, 2'd1, 16'h0002);
    end
    wr(0, 2'd2, 16'h0001);
    ce = 1'b1;
    set_all(4'd3);
    #2;
    chk("R8 no capture before falling edge", {24'd0, cell_out}, 32'h55);
    #2;
    chk("R8 captured on falling edge", {24'd0, cell_out}, 32'h00);
    set_all(4'd12);
    #4;
    chk("R8 rising edge does not capture", {24'd0, cell_out}, 32'h00);
    #4;
    chk("R8 next falling edge captures", {24'd0, cell_out}, 32'hFF);
    ce = 1'b0;
    @(posedge clk); #1;
    wr(0, 2'd2, 16'h0002);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_lut();
    t_carry();
    t_reg();
    t_sync();
    t_async();
    t_neg();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule